// File: doc/BRIEF.md
# Pipelined Burst SRAM Front-End

This block sits in front of a synchronous burst static memory organised as two 9-bit byte lanes, each lane being eight data bits and one parity bit. At every rising clock edge it samples three chip enables, two address strobes, an advance input, a burst-order select and the write controls. A recognised strobe captures an 18-bit address. The upper sixteen bits are held for the whole burst. The two low bits seed a 2-bit burst counter, and the advance input then steps that counter in either linear or interleaved order.

The two strobes do not have equal standing. The processor-side strobe wins when both are low in the same cycle, but chip enable 1 gates it. The controller-side strobe is never gated. Writes come either from a global write, which covers both lanes, or from a byte-write enable combined with per-lane selects. Read data is registered, so it appears one clock after the address it belongs to. It reaches the output only while output enable is low and no write control is asserted.

The storage is a behavioural array of 2^arrayBits words. Words are indexed by the low arrayBits bits of the current burst address, so higher addresses alias into the array.

Top module: `burstSramFront`

## Requirements
- R1: While rstN is low at a clock edge, the access is cleared. After reset, busEn is 0 and rdData/rdPar are 0 until a new access starts.
- R2: A strobe (an active-low strobe sampled low) with ce1N=0, ce2=1 and ce3N=0 captures addrIn. The word index becomes {addrIn[17:2], counter}, and the counter is seeded with addrIn[1:0].
- R3: If strobeProcN and strobeCtrlN are both low while ce1N=0, the processor strobe is the one recognised, and it ignores the write controls on its capture edge. A controller-strobe capture with write controls asserted writes the captured address on that same edge.
- R4: When ce1N=1, strobeProcN is ignored. With strobeCtrlN high, the running access continues unchanged.
- R5: A recognised strobe while any chip enable is inactive ends the access, and no further read data is driven.
- R6: If modeInterleave=0 at capture, each edge with advN=0 steps the low bits through start+n modulo 4.
- R7: If modeInterleave=1 at capture, each edge with advN=0 steps the low bits through start XOR n.
- R8: With advN=1 the burst address holds. The upper bits never change within a burst, and after four advances the low bits return to their start value.
- R9: globalWrN=0 writes both lanes, whatever the values of byteWrEnN and byteSelN.
- R10: With globalWrN=1 and byteWrEnN=0, byteSelN[0]=0 writes lane 0 ({wrPar[0], wrData[7:0]}) and byteSelN[1]=0 writes lane 1 ({wrPar[1], wrData[15:8]}). An unselected lane keeps its contents.
- R11: With globalWrN=1 and byteWrEnN=1, byteSelN has no effect, and the cycle is a read.
- R12: On each read edge of an active access, the word at the current burst address is registered. busEn is 1 exactly when that registered data is valid, oeN=0, globalWrN=1 and byteWrEnN=1; otherwise rdData and rdPar are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| addrIn | input | 18 | Word address |
| strobeProcN | input | 1 | Processor-side address strobe, active low, gated by ce1N |
| strobeCtrlN | input | 1 | Controller-side address strobe, active low |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| advN | input | 1 | Burst advance, active low |
| modeInterleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| globalWrN | input | 1 | Global write, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| byteSelN | input | 2 | Per-lane write selects, active low |
| oeN | input | 1 | Output enable, active low |
| wrData | input | 16 | Write data, two 8-bit lanes |
| wrPar | input | 2 | Write parity, one bit per lane |
| rdData | output | 16 | Registered read data, 0 when not driven |
| rdPar | output | 2 | Registered read parity, 0 when not driven |
| busEn | output | 1 | High while the read bus is driven |

## Verification
The embedded assertions check the following on every cycle:
- the burst-counter step in both orders, the hold under a high advance and the stability of the upper address;
- that a deselect ends the access;
- that the processor strobe never writes on its capture edge;
- that valid read data always follows a read edge.

Only the bench scenarios can show the data-level effects. Those are lane masking against a reference memory, aliasing of written words and the exact gating of the bus by output enable and the write controls. The same holds for the combined effect of chip-enable gating on which strobe acts.

// File: rtl/burstSramPkg.sv
package burstSramPkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic             load;      // capture a new address
    logic             deselect;  // end the running access
    logic             wrAtLoad;  // write to the captured address
    logic             wrAtCur;   // write to the current burst address
    logic             rdCur;     // register the current burst word
    logic [LANES-1:0] laneMask;  // lanes touched by a write
  } cycleCmd_t;
endpackage

// File: rtl/burstCtrl.sv
module burstCtrl
  import burstSramPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       addrLow,
  input  logic             strobeProcN,
  input  logic             strobeCtrlN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             advN,
  input  logic             modeInterleave,
  input  logic             globalWrN,
  input  logic             byteWrEnN,
  input  logic [LANES-1:0] byteSelN,
  output cycleCmd_t        cmd,
  output logic [1:0]       burstLow
);

  logic       active;
  logic       modeReg;
  logic [1:0] startLow;
  logic [1:0] count;
  logic       chipSel;
  logic       procSeen;
  logic       strobeSeen;
  logic [LANES-1:0] laneMask;

  assign chipSel    = !ce1N && ce2 && !ce3N;
  assign procSeen   = !strobeProcN && !ce1N;
  assign strobeSeen = procSeen || !strobeCtrlN;

  always_comb begin
    if (!globalWrN)      laneMask = '1;
    else if (!byteWrEnN) laneMask = ~byteSelN;
    else                 laneMask = '0;
  end

  always_comb begin
    cmd.laneMask = laneMask;
    cmd.load     = strobeSeen && chipSel;
    cmd.deselect = strobeSeen && !chipSel;
    cmd.wrAtLoad = strobeSeen && chipSel && !procSeen && (|laneMask);
    cmd.wrAtCur  = active && !strobeSeen && (|laneMask);
    cmd.rdCur    = active && !(!strobeSeen && (|laneMask));
  end

  assign burstLow = modeReg ? (startLow ^ count) : (startLow + count);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      modeReg  <= 1'b0;
      startLow <= 2'd0;
      count    <= 2'd0;
    end else if (cmd.load) begin
      active   <= 1'b1;
      modeReg  <= modeInterleave;
      startLow <= addrLow;
      count    <= 2'd0;
    end else if (cmd.deselect) begin
      active   <= 1'b0;
    end else if (active && !advN) begin
      count    <= count + 2'd1;
    end
  end

  // R5
  deselect_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.deselect |=> !active);

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !strobeSeen && advN) |=> $stable(burstLow));

  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !strobeSeen && !advN && !modeReg) |=> (burstLow == $past(burstLow) + 2'd1));

  // R7
  interleave_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !strobeSeen && !advN && modeReg) |=> ((burstLow ^ startLow) == $past(count) + 2'd1));

  // R3
  proc_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeProcN && !ce1N) |-> !cmd.wrAtLoad);

endmodule

// File: rtl/burstData.sv
module burstData
  import burstSramPkg::*;
#(
  parameter int addrWidth = 18,
  parameter int arrayBits = 8,
  parameter int laneBits  = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cycleCmd_t                  cmd,
  input  logic [addrWidth-1:0]       addrIn,
  input  logic [1:0]                 burstLow,
  input  logic [LANES*(laneBits-1)-1:0] wrData,
  input  logic [LANES-1:0]           wrPar,
  output logic [LANES*(laneBits-1)-1:0] rdData,
  output logic [LANES-1:0]           rdPar,
  output logic                       rdValid
);

  localparam int depth    = 1 << arrayBits;
  localparam int dataBits = laneBits - 1;

  logic [addrWidth-3:0] upperReg;
  logic [addrWidth-1:0] curAddr;
  logic [arrayBits-1:0] curIdx;
  logic [arrayBits-1:0] loadIdx;
  logic                 unusedHigh;

  assign curAddr    = {upperReg, burstLow};
  assign curIdx     = curAddr[arrayBits-1:0];
  assign loadIdx    = addrIn[arrayBits-1:0];
  assign unusedHigh = ^curAddr[addrWidth-1:arrayBits];

  always_ff @(posedge clk) begin
    if (!rstN)         upperReg <= '0;
    else if (cmd.load) upperReg <= addrIn[addrWidth-1:2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= cmd.rdCur;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [laneBits-1:0] memLane [depth];
    logic [laneBits-1:0] laneIn;
    logic [laneBits-1:0] laneOut;

    assign laneIn = {wrPar[g], wrData[g*dataBits +: dataBits]};

    always_ff @(posedge clk) begin
      if (cmd.wrAtLoad && cmd.laneMask[g])
        memLane[loadIdx] <= laneIn;
      else if (cmd.wrAtCur && cmd.laneMask[g])
        memLane[curIdx] <= laneIn;
    end

    always_ff @(posedge clk) begin
      if (!rstN)          laneOut <= '0;
      else if (cmd.rdCur) laneOut <= memLane[curIdx];
    end

    assign rdData[g*dataBits +: dataBits] = laneOut[dataBits-1:0];
    assign rdPar[g]                       = laneOut[laneBits-1];
  end

  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> $stable(upperReg));

  // R12
  valid_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(cmd.rdCur));

endmodule

// File: rtl/burstSramFront.sv
module burstSramFront
  import burstSramPkg::*;
#(
  parameter int addrWidth = 18,
  parameter int arrayBits = 8,
  parameter int laneBits  = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [addrWidth-1:0] addrIn,
  input  logic                 strobeProcN,
  input  logic                 strobeCtrlN,
  input  logic                 ce1N,
  input  logic                 ce2,
  input  logic                 ce3N,
  input  logic                 advN,
  input  logic                 modeInterleave,
  input  logic                 globalWrN,
  input  logic                 byteWrEnN,
  input  logic [1:0]           byteSelN,
  input  logic                 oeN,
  input  logic [15:0]          wrData,
  input  logic [1:0]           wrPar,
  output logic [15:0]          rdData,
  output logic [1:0]           rdPar,
  output logic                 busEn
);

  cycleCmd_t   cmd;
  logic [1:0]  burstLow;
  logic [15:0] wordData;
  logic [1:0]  wordPar;
  logic        rdValid;

  burstCtrl uCtrl (
    .clk(clk), .rstN(rstN), .addrLow(addrIn[1:0]),
    .strobeProcN(strobeProcN), .strobeCtrlN(strobeCtrlN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .advN(advN),
    .modeInterleave(modeInterleave), .globalWrN(globalWrN),
    .byteWrEnN(byteWrEnN), .byteSelN(byteSelN),
    .cmd(cmd), .burstLow(burstLow)
  );

  burstData #(.addrWidth(addrWidth), .arrayBits(arrayBits), .laneBits(laneBits)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .addrIn(addrIn), .burstLow(burstLow),
    .wrData(wrData), .wrPar(wrPar),
    .rdData(wordData), .rdPar(wordPar), .rdValid(rdValid)
  );

  assign busEn  = rdValid && !oeN && globalWrN && byteWrEnN;
  assign rdData = busEn ? wordData : '0;
  assign rdPar  = busEn ? wordPar  : '0;

  // R12
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |-> (rdData == '0 && rdPar == '0));

endmodule

// File: tb/tb_burstSramFront.sv
module tb_burstSramFront;
  localparam int ARR = 256;

  logic clk = 0;
  always #10 clk = ~clk;

  logic        rstN;
  logic [17:0] addr;
  logic pN, cN, e1N, e2, e3N, aN, md, gN, bN, oN;
  logic [1:0]  sN, par;
  logic [15:0] dat;
  logic [15:0] rdData;
  logic [1:0]  rdPar;
  logic        busEn;

  burstSramFront dut (
    .clk(clk), .rstN(rstN), .addrIn(addr), .strobeProcN(pN), .strobeCtrlN(cN),
    .ce1N(e1N), .ce2(e2), .ce3N(e3N), .advN(aN), .modeInterleave(md),
    .globalWrN(gN), .byteWrEnN(bN), .byteSelN(sN), .oeN(oN),
    .wrData(dat), .wrPar(par), .rdData(rdData), .rdPar(rdPar), .busEn(busEn)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  string req = "R1";

  // reference state
  int mActive, mUpper, mStart, mCnt, mMode;
  logic [8:0] m0 [int];
  logic [8:0] m1 [int];
  bit expValid, expKnown;
  logic [17:0] expWord;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeLanes(int idx, int mask);
    if (mask & 1) m0[idx] = {par[0], dat[7:0]};
    if (mask & 2) m1[idx] = {par[1], dat[15:8]};
  endtask

  task automatic modelEdge();
    bit chip, proc, evt, rd;
    int mask, low, idx;
    if (!rstN) begin
      mActive = 0; mCnt = 0; mStart = 0; mMode = 0; mUpper = 0; expValid = 0;
      return;
    end
    chip = !e1N && e2 && !e3N;
    proc = !pN && !e1N;
    evt  = proc || !cN;
    mask = !gN ? 3 : (!bN ? ((~sN) & 3) : 0);
    low  = mMode ? (mStart ^ mCnt) : ((mStart + mCnt) & 3);
    idx  = ((mUpper << 2) | low) % ARR;
    rd   = (mActive != 0) && !(!evt && mask != 0);
    expValid = rd;
    if (rd) begin
      expKnown = m0.exists(idx) && m1.exists(idx);
      if (expKnown) expWord = {m1[idx], m0[idx]};
    end
    if (evt && chip && !proc && mask != 0) writeLanes(int'(addr) % ARR, mask);
    else if (mActive != 0 && !evt && mask != 0) writeLanes(idx, mask);
    if (evt && chip) begin
      mActive = 1; mUpper = int'(addr) >> 2; mStart = int'(addr) & 3; mCnt = 0; mMode = md;
    end else if (evt) mActive = 0;
    else if (mActive != 0 && !aN) mCnt = (mCnt + 1) & 3;
  endtask

  task automatic compareOut();
    bit expBus;
    expBus = expValid && !oN && gN && bN;
    check(busEn == expBus, {req, " bus enable"}, busEn, expBus);
    if (expBus && expKnown)
      check({rdPar[1], rdData[15:8], rdPar[0], rdData[7:0]} == expWord,
            {req, " read word"}, {rdPar[1], rdData[15:8], rdPar[0], rdData[7:0]}, expWord);
    if (!expBus)
      check(rdData == 0 && rdPar == 0, {req, " idle bus"}, {rdPar, rdData}, 0);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelEdge();
      #2;
      compareOut();
    end
  endtask

  task automatic idle();
    pN = 1; cN = 1; e1N = 0; e2 = 1; e3N = 0; aN = 1; gN = 1; bN = 1; sN = 2'b11; oN = 0;
  endtask

  task automatic start(bit useProc, int a, bit mode);
    addr = a[17:0]; md = mode;
    if (useProc) pN = 0; else cN = 0;
    tick(1);
    pN = 1; cN = 1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(); addr = 0; md = 0; dat = 0; par = 0; rstN = 0;
    // R1 reset state
    req = "R1";
    tick(3);
    rstN = 1;
    tick(2);

    // R9 fill the array with global writes, byte controls arbitrary
    req = "R9";
    for (int b = 0; b < ARR / 4; b++) begin
      bN = b[0]; sN = b[2:1];
      gN = 0; dat = {8'(b * 4) ^ 8'h5A, 8'(b * 4)}; par = 2'(b);
      aN = 0;
      start(0, b * 4 + 1024, 0);
      for (int k = 1; k < 4; k++) begin
        dat = {8'(b * 4 + k) ^ 8'h5A, 8'(b * 4 + k)}; par = 2'(b + k);
        tick(1);
      end
      idle();
    end
    tick(1);

    // R6 and R2 linear bursts from every start offset
    req = "R6";
    for (int s = 0; s < 4; s++) begin
      aN = 0; start(1, 40 + s, 0); tick(5); idle();
    end
    // R2 capture of distinct upper bits
    req = "R2";
    start(1, 18'h2_3F01, 0); aN = 0; tick(4); idle();

    // R7 interleaved bursts from every start offset
    req = "R7";
    for (int s = 0; s < 4; s++) begin
      aN = 0; start(1, 100 + s, 1); tick(5); idle();
    end

    // R8 hold with advance high, then wrap
    req = "R8";
    start(1, 201, 0); tick(3); aN = 0; tick(4); aN = 1; tick(2); idle();

    // R3 both strobes low with write controls: processor wins, no write
    req = "R3";
    gN = 0; dat = 16'hDEAD; par = 2'b11; pN = 0; cN = 0; addr = 18'd60; md = 0;
    tick(1); idle(); tick(1); tick(2);
    // controller strobe with write writes on the capture edge
    gN = 0; dat = 16'hBEEF; par = 2'b01; cN = 0; addr = 18'd61;
    tick(1); idle(); pN = 0; addr = 18'd61; tick(1); idle(); tick(2);

    // R4 processor strobe ignored when ce1N high
    req = "R4";
    start(1, 8, 0); aN = 0; e1N = 1; pN = 0; addr = 18'd150; tick(1);
    pN = 1; e1N = 0; tick(3); idle();

    // R5 deselect through any inactive chip enable
    req = "R5";
    start(1, 20, 0); tick(1); e2 = 0; pN = 0; tick(1); idle(); tick(3);
    start(1, 24, 0); tick(1); e3N = 1; cN = 0; tick(1); idle(); tick(3);
    start(1, 28, 0); tick(1); e1N = 1; cN = 0; tick(1); idle(); tick(3);

    // R10 byte writes per lane
    req = "R10";
    start(1, 72, 0);
    bN = 0; sN = 2'b10; dat = 16'h1122; par = 2'b00; tick(1);
    sN = 2'b01; dat = 16'h3344; par = 2'b11; aN = 0; tick(1);
    aN = 1; sN = 2'b00; dat = 16'h5566; par = 2'b10; tick(1);
    idle(); start(1, 72, 0); aN = 0; tick(4); idle();

    // R11 selects without byte-write enable are ignored
    req = "R11";
    start(1, 76, 0); sN = 2'b00; dat = 16'hFFFF; par = 2'b11; tick(2);
    idle(); start(1, 76, 0); tick(2); idle();

    // R12 output enable and write gating of the bus
    req = "R12";
    start(1, 90, 0); oN = 1; tick(2); oN = 0; tick(1); idle();
    start(1, 90, 0); tick(1);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      pN = (r[3:0] != 0); cN = (r[7:4] != 0); e1N = (r[10:8] == 0); e2 = (r[13:11] != 0);
      e3N = (r[16:14] == 0); aN = r[17]; md = r[18]; gN = (r[21:19] != 0);
      bN = (r[23:22] == 0) ? 1'b0 : 1'b1; sN = r[25:24]; oN = (r[28:26] == 0);
      addr = 18'($urandom); dat = 16'($urandom); par = 2'($urandom);
      tick(1);
    end
    idle(); tick(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule